// File: doc/BRIEF.md
# Flat Page-Table Address Translator

This block turns 32-bit device virtual addresses into physical addresses. The page table is one flat array in memory with one 32-bit word per 4 KB page. A 4 GB virtual space therefore needs 2^20 words, which is 4 MB. A small fully associative TLB sits in front of the table. When a lookup misses, the block reads exactly one table word through a simple memory read port. If that word is marked valid, the block stores it in the TLB and returns the translation. If it is not marked valid, the block reports a translation fault and also pulses a signal toward a fault unit.

Software uses a register port to do three things: set the table base, drop every cached translation, or drop only the translations whose pages lie in an inclusive page range. A range drop raises a sticky completion flag, which software polls and later clears by writing zero. An invalidate that arrives while a table read is in flight waits until that read completes. The translator holds off new requests until every pending invalidate has been applied.

Top module: `pt_xlate`

## Requirements
- R1: After reset:
  - `req_ready` is 1, and `rsp_valid`, `fault_pulse` and `mem_req` are 0.
  - The base register (offset 0x000), the select register (0x5D8) and the done register (0x60C) all read 0.
  - The TLB is empty, so the first lookup of any page reads memory.
- R2: On a TLB miss, the block raises `mem_req` for exactly one cycle, with `mem_addr` = base + vaddr[31:12]*4. Only one read is in flight at a time, and `req_ready` stays 0 until `mem_ack` returns.
- R3: For a table word with bit 1 set, the response carries `rsp_paddr` = {word[31:12], vaddr[11:0]}, `rsp_fault` = 0 and `rsp_hit` = 0. The flag bits in word[11:0], including the non-secure bit 3, never appear in the address.
- R4: A table word with bit 1 clear produces a response with `rsp_fault` = 1 and `rsp_paddr` = 0, together with a `fault_pulse` that lasts exactly one cycle. The word is not cached, so the next lookup of that page reads memory again.
- R5: A lookup of a cached page responds in the cycle after it is accepted, with `rsp_hit` = 1, the correct address, and no memory read.
- R6: The TLB holds 4 pages and refills them in round-robin order. The fifth distinct page overwrites the page that was filled first.
- R7: Writing a value with bit 1 set to the invalidate register (0x5C0) drops every cached page. This only happens while the select register bits [1:0] are not both zero.
- R8: While select bits [1:0] are both 0, writes to the invalidate register have no effect.
- R9: Writing a value with bit 0 set to the invalidate register drops exactly the cached pages whose page number lies between the start bound (0x5C4) and the end bound (0x5C8), inclusive. Both bounds are stored masked with 0xFFFFF000.
- R10: The done register (0x60C) reads 1 once a range invalidate has been applied. A full invalidate does not set it. It stays 1 through nonzero writes and clears only when software writes 0 to it.
- R11: An invalidate written while a table read is in flight does not disturb that response. It is applied once the read finishes, so a fetched page that lies inside the invalidated range does not survive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_vaddr | input | 32 | Virtual address to translate |
| req_ready | output | 1 | Request accepted on this edge when high |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| rsp_hit | output | 1 | Response served from the TLB |
| rsp_fault | output | 1 | Table word was not valid |
| fault_pulse | output | 1 | One-cycle fault notification |
| mem_req | output | 1 | One-cycle table read request |
| mem_addr | output | 32 | Byte address of the table word |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 32 | Table word |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |

## Verification
Corrupted TLB state shows up at the ports on the next lookup of the affected page.
- A stale or wrongly kept entry shows as `rsp_hit` with no read on the memory port, where a miss with a read is expected.
- A wrongly dropped entry shows as an extra memory read.
- Errors in the replacement pointer or the range comparison take longer to show: they appear only once a later lookup touches the evicted or retained page.

The bench therefore counts memory reads around every lookup. It follows each invalidate with lookups on both sides of each range bound.

// File: rtl/pt_xlate.sv
module pt_xlate #(
  parameter int TLB_N      = 4,
  parameter int VA_W       = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int REG_AW     = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_vaddr,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [VA_W-1:0]   rsp_paddr,
  output logic              rsp_hit,
  output logic              rsp_fault,
  output logic              fault_pulse,
  output logic              mem_req,
  output logic [VA_W-1:0]   mem_addr,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata
);
  localparam int VPN_W = VA_W - PAGE_SHIFT;
  localparam int IDX_W = (TLB_N > 1) ? $clog2(TLB_N) : 1;
  localparam logic [REG_AW-1:0] OFF_BASE = REG_AW'(12'h000);
  localparam logic [REG_AW-1:0] OFF_INV  = REG_AW'(12'h5C0);
  localparam logic [REG_AW-1:0] OFF_LO   = REG_AW'(12'h5C4);
  localparam logic [REG_AW-1:0] OFF_HI   = REG_AW'(12'h5C8);
  localparam logic [REG_AW-1:0] OFF_SEL  = REG_AW'(12'h5D8);
  localparam logic [REG_AW-1:0] OFF_DONE = REG_AW'(12'h60C);
  localparam logic [VA_W-1:0]   PG_MASK  = {{VPN_W{1'b1}}, {PAGE_SHIFT{1'b0}}};

  typedef enum logic {S_IDLE, S_FETCH} st_t;
  st_t st_q;

  logic [VA_W-1:0] base_q, lo_q, hi_q;
  logic [1:0]      sel_q;
  logic            done_q, pend_all_q, pend_rng_q;
  logic [PAGE_SHIFT-1:0] off_q;

  logic [TLB_N-1:0] tv_q;
  logic [VPN_W-1:0] tvpn_q [TLB_N];
  logic [VPN_W-1:0] tppn_q [TLB_N];
  logic [IDX_W-1:0] rr_q;

  logic [VPN_W-1:0] req_vpn, lo_vpn, hi_vpn, hit_ppn;
  logic [TLB_N-1:0] hit_vec, in_rng;
  logic idle, accept, any_hit, inv_wr, fill, ent_ok;
  logic unused_ok;

  assign req_vpn   = req_vaddr[VA_W-1:PAGE_SHIFT];
  assign lo_vpn    = lo_q[VA_W-1:PAGE_SHIFT];
  assign hi_vpn    = hi_q[VA_W-1:PAGE_SHIFT];
  assign idle      = (st_q == S_IDLE);
  assign req_ready = idle && !pend_all_q && !pend_rng_q;
  assign accept    = req_valid && req_ready;
  assign any_hit   = |hit_vec;
  assign inv_wr    = reg_we && (reg_addr == OFF_INV) && (sel_q != 2'b00);
  assign ent_ok    = mem_rdata[1];
  assign fill      = (st_q == S_FETCH) && mem_ack && ent_ok;
  assign unused_ok = ^{mem_rdata[PAGE_SHIFT-1:2], mem_rdata[0]};

  for (genvar g = 0; g < TLB_N; g++) begin : g_cmp
    assign hit_vec[g] = tv_q[g] && (tvpn_q[g] == req_vpn);
    assign in_rng[g]  = (tvpn_q[g] >= lo_vpn) && (tvpn_q[g] <= hi_vpn);
  end

  always_comb begin
    hit_ppn = '0;
    for (int i = 0; i < TLB_N; i++)
      if (hit_vec[i]) hit_ppn = hit_ppn | tppn_q[i];
  end

  always_comb begin
    case (reg_addr)
      OFF_BASE: reg_rdata = base_q;
      OFF_LO:   reg_rdata = lo_q;
      OFF_HI:   reg_rdata = hi_q;
      OFF_SEL:  reg_rdata = {30'd0, sel_q};
      OFF_DONE: reg_rdata = {31'd0, done_q};
      default:  reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0; lo_q <= '0; hi_q <= '0; sel_q <= '0;
      done_q <= 1'b0; pend_all_q <= 1'b0; pend_rng_q <= 1'b0;
    end else begin
      if (reg_we && reg_addr == OFF_BASE) base_q <= reg_wdata;
      if (reg_we && reg_addr == OFF_LO)   lo_q   <= reg_wdata & PG_MASK;
      if (reg_we && reg_addr == OFF_HI)   hi_q   <= reg_wdata & PG_MASK;
      if (reg_we && reg_addr == OFF_SEL)  sel_q  <= reg_wdata[1:0];
      pend_all_q <= (pend_all_q && !idle) || (inv_wr && reg_wdata[1]);
      pend_rng_q <= (pend_rng_q && !idle) || (inv_wr && reg_wdata[0]);
      if (idle && pend_rng_q) done_q <= 1'b1;
      else if (reg_we && reg_addr == OFF_DONE && reg_wdata == 32'd0) done_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tv_q <= '0;
      rr_q <= '0;
      for (int i = 0; i < TLB_N; i++) begin
        tvpn_q[i] <= '0;
        tppn_q[i] <= '0;
      end
    end else if (fill) begin
      tv_q[rr_q]   <= 1'b1;
      tvpn_q[rr_q] <= mem_addr[VPN_W+1:2] - base_q[VPN_W+1:2];
      tppn_q[rr_q] <= mem_rdata[31:PAGE_SHIFT];
      rr_q <= (rr_q == IDX_W'(TLB_N-1)) ? '0 : rr_q + 1'b1;
    end else if (idle && pend_all_q) begin
      tv_q <= '0;
    end else if (idle && pend_rng_q) begin
      tv_q <= tv_q & ~in_rng;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= S_IDLE;
      off_q <= '0;
      mem_req <= 1'b0; mem_addr <= '0;
      rsp_valid <= 1'b0; rsp_paddr <= '0; rsp_hit <= 1'b0; rsp_fault <= 1'b0;
      fault_pulse <= 1'b0;
    end else begin
      rsp_valid   <= 1'b0;
      fault_pulse <= 1'b0;
      mem_req     <= 1'b0;
      case (st_q)
        S_IDLE: if (accept) begin
          off_q <= req_vaddr[PAGE_SHIFT-1:0];
          if (any_hit) begin
            rsp_valid <= 1'b1;
            rsp_hit   <= 1'b1;
            rsp_fault <= 1'b0;
            rsp_paddr <= {hit_ppn, req_vaddr[PAGE_SHIFT-1:0]};
          end else begin
            st_q     <= S_FETCH;
            mem_req  <= 1'b1;
            mem_addr <= base_q + {{(VA_W-VPN_W-2){1'b0}}, req_vpn, 2'b00};
          end
        end
        S_FETCH: if (mem_ack) begin
          st_q        <= S_IDLE;
          rsp_valid   <= 1'b1;
          rsp_hit     <= 1'b0;
          rsp_fault   <= !ent_ok;
          fault_pulse <= !ent_ok;
          rsp_paddr   <= ent_ok ? {mem_rdata[31:PAGE_SHIFT], off_q} : '0;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  AST_ONE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R6
  AST_STALL_IN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_FETCH) |-> !req_ready); // R2
  AST_SINGLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req); // R2
  AST_FAULT_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    fault_pulse |-> (rsp_valid && rsp_fault && rsp_paddr == '0)); // R4
  AST_FAULT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    fault_pulse |=> !fault_pulse); // R4
  AST_RSP_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(accept || (st_q == S_FETCH && mem_ack))); // R3
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !(reg_we && reg_addr == OFF_DONE && reg_wdata == 32'd0)) |=> done_q); // R10
endmodule

// File: tb/pt_xlate_test.sv
module pt_xlate_test;
  localparam logic [31:0] BASE = 32'h4000_0000;
  localparam logic [11:0] A_BASE = 12'h000, A_INV = 12'h5C0, A_LO = 12'h5C4,
                          A_HI = 12'h5C8, A_SEL = 12'h5D8, A_DONE = 12'h60C;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0; logic [31:0] req_vaddr = '0; logic req_ready;
  logic rsp_valid, rsp_hit, rsp_fault, fault_pulse, mem_req;
  logic [31:0] rsp_paddr, mem_addr, reg_rdata;
  logic mem_ack = 1'b0; logic [31:0] mem_rdata = '0;
  logic reg_we = 1'b0; logic [11:0] reg_addr = '0; logic [31:0] reg_wdata = '0;

  int tests = 0, fails = 0, reads = 0, cyc = 0;
  logic [31:0] last_addr = '0;

  always #4 clk = ~clk;

  pt_xlate uut (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_hit(rsp_hit),
    .rsp_fault(rsp_fault), .fault_pulse(fault_pulse), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  function automatic logic [31:0] pte(input logic [19:0] vpn);
    pte = {vpn + 20'h12345, (vpn[3:0] == 4'hF) ? 12'h008 : 12'h00A};
  endfunction

  // table memory: answers 3 cycles after the request
  int cnt = 0; bit busy = 0;
  always @(negedge clk) begin
    mem_ack = 1'b0;
    if (mem_req) begin
      busy = 1; cnt = 2; reads++; last_addr = mem_addr;
    end else if (busy) begin
      if (cnt == 0) begin
        mem_ack = 1'b1; mem_rdata = pte(20'((last_addr - BASE) >> 2)); busy = 0;
      end else cnt--;
    end
  end

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      fails++; $display("FAIL watchdog expired");
      summary(); $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rreg(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic xl(input logic [31:0] va, input bit eh, input bit ef, input string req);
    int r0, lat;
    logic [31:0] ep;
    ep = ef ? 32'd0 : {va[31:12] + 20'h12345, va[11:0]};
    do @(negedge clk); while (!req_ready);
    r0 = reads;
    req_valid = 1'b1; req_vaddr = va;
    @(posedge clk); @(negedge clk); req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid && lat < 40) begin @(negedge clk); lat++; end
    chk(rsp_valid && rsp_hit == eh && rsp_fault == ef && rsp_paddr == ep, req,
        {rsp_paddr[31:3], rsp_valid, rsp_hit, rsp_fault}, {ep[31:3], 1'b1, eh, ef});
    chk(fault_pulse == ef, "R4 fault pulse", 32'(fault_pulse), 32'(ef));
    if (eh) chk(lat == 1 && reads == r0, "R5 hit latency/no read", lat, 1);
    else begin
      chk(reads == r0 + 1, "R2 one read per miss", reads - r0, 1);
      chk(last_addr == BASE + {10'd0, va[31:12], 2'b00}, "R2 fetch address",
          last_addr, BASE + {10'd0, va[31:12], 2'b00});
    end
    @(negedge clk);
    if (ef) chk(!fault_pulse, "R4 pulse length", 32'(fault_pulse), 0);
  endtask

  // {vaddr, expect hit, expect fault}
  localparam logic [33:0] VEC [11] = '{
    {32'h0000_1234, 1'b0, 1'b0}, {32'h0000_1FFC, 1'b1, 1'b0},
    {32'h0000_2010, 1'b0, 1'b0}, {32'h0000_F008, 1'b0, 1'b1},
    {32'h0000_F008, 1'b0, 1'b1}, {32'h0003_3ABC, 1'b0, 1'b0},
    {32'h0004_4000, 1'b0, 1'b0}, {32'h0000_1000, 1'b1, 1'b0},
    {32'h0005_5000, 1'b0, 1'b0}, {32'h0000_1234, 1'b0, 1'b0},
    {32'h0003_3000, 1'b1, 1'b0}};

  initial begin
    logic [31:0] d;
    int n;
    repeat (3) @(negedge clk);
    chk(req_ready && !rsp_valid && !fault_pulse && !mem_req, "R1 reset outputs",
        {28'd0, req_ready, rsp_valid, fault_pulse, mem_req}, 32'h8);
    rst_n = 1'b1;
    rreg(A_DONE, d); chk(d == 0, "R1 done reset", d, 0);
    rreg(A_SEL, d);  chk(d == 0, "R1 select reset", d, 0);
    rreg(A_BASE, d); chk(d == 0, "R1 base reset", d, 0);
    wreg(A_BASE, BASE);

    for (int i = 0; i < 11; i++)
      xl(VEC[i][33:2], VEC[i][1], VEC[i][0], "R3/R4/R5/R6 table step");

    wreg(A_INV, 32'h2);
    xl(32'h0004_4010, 1'b1, 1'b0, "R8 invalidate ignored with select 0");
    wreg(A_SEL, 32'h3);
    wreg(A_INV, 32'h2);
    xl(32'h0004_4010, 1'b0, 1'b0, "R7 full invalidate");
    rreg(A_DONE, d); chk(d == 0, "R10 full invalidate leaves done", d, 0);

    xl(32'h0001_0000, 1'b0, 1'b0, "R6 fill");
    xl(32'h0002_0000, 1'b0, 1'b0, "R6 fill");
    xl(32'h0003_0000, 1'b0, 1'b0, "R6 fill");
    wreg(A_LO, 32'h0002_0ABC); rreg(A_LO, d); chk(d == 32'h0002_0000, "R9 start mask", d, 32'h0002_0000);
    wreg(A_HI, 32'h0003_0FFF); rreg(A_HI, d); chk(d == 32'h0003_0000, "R9 end mask", d, 32'h0003_0000);
    wreg(A_INV, 32'h1);
    n = 0; d = 0;
    while (d == 0 && n < 20) begin rreg(A_DONE, d); n++; end
    chk(d != 0, "R10 done after range", d, 1);
    xl(32'h0001_0004, 1'b1, 1'b0, "R9 below range kept");
    xl(32'h0004_4004, 1'b1, 1'b0, "R9 above range kept");
    xl(32'h0002_0008, 1'b0, 1'b0, "R9 start page dropped");
    xl(32'h0003_0008, 1'b0, 1'b0, "R9 end page dropped");
    wreg(A_DONE, 32'h5); rreg(A_DONE, d); chk(d == 1, "R10 nonzero write keeps done", d, 1);
    wreg(A_DONE, 32'h0); rreg(A_DONE, d); chk(d == 0, "R10 zero write clears", d, 0);

    // R11: invalidate during fetch
    wreg(A_LO, 32'h0007_0000); wreg(A_HI, 32'h0007_0000);
    do @(negedge clk); while (!req_ready);
    req_valid = 1'b1; req_vaddr = 32'h0007_0123;
    @(posedge clk); @(negedge clk); req_valid = 1'b0;
    chk(!req_ready, "R2 ready low in fetch", 32'(req_ready), 0);
    reg_we = 1'b1; reg_addr = A_INV; reg_wdata = 32'h1;
    @(posedge clk); @(negedge clk); reg_we = 1'b0;
    n = 0;
    while (!rsp_valid && n < 40) begin @(negedge clk); n++; end
    chk(rsp_valid && !rsp_fault && rsp_paddr == 32'h123B_5123, "R11 response intact",
        rsp_paddr, 32'h123B_5123);
    n = 0; d = 0;
    while (d == 0 && n < 20) begin rreg(A_DONE, d); n++; end
    chk(d != 0, "R11 done after deferred range", d, 1);
    xl(32'h0007_0FF0, 1'b0, 1'b0, "R11 fetched page dropped");

    summary();
    $finish;
  end
endmodule